// File: doc/BRIEF.md
# Three-Cycle Enabled Wide Adder

This block adds two wide unsigned operand buses whose combinational sum is allowed to take up to three clock periods to settle. Both operands are registered before the adder, and the adder output is registered again. All three registers load only on a shared load strobe. The strobe comes from a small circulating one-hot ring, so each launched operand pair has a full three-cycle window before its sum is captured. The block is meant for a datapath where the adder is too slow for one cycle. That datapath can still accept a new operand pair every third clock and present a fresh result at the same rate.

The ring passes through three phases: PH_LOAD (ring `001`), PH_WAIT (`010`) and PH_FIRE (`100`). It advances LOAD→WAIT→FIRE→LOAD on every clock, and the strobe is high in PH_FIRE. A two-state sequencer tracks whether the result register holds a real sum. It starts in SEQ_EMPTY after reset. It moves SEQ_EMPTY→SEQ_PRIMED on the first strobe, because the first strobe launches operands but captures only the cleared operand registers. It stays in SEQ_PRIMED until the next reset. A one-cycle valid pulse follows every strobe taken in SEQ_PRIMED.

Top module: `mca_wide_adder`

## Requirements
- R1: While reset is high, the ring is forced to `001` and the operand and result registers are cleared. In the cycle after a reset edge, `sum_o`=0, `carry_o`=0, `valid_o`=0 and `strobe_o`=0.
- R2: `strobe_o` is first high in the third clock cycle after reset is released, meaning after the second rising edge that sees reset low. After that it is high for exactly one cycle out of every three.
- R3: Operands are sampled only on a rising edge where `strobe_o` is high, and `sum_o` changes only on such an edge. Operand changes at any other time have no effect on the outputs.
- R4: On each strobe edge, `sum_o` takes `(A + B) mod 2^DATA_W`, where A and B are the operands sampled on the previous strobe edge.
- R5: `valid_o` is high for exactly one cycle, in the cycle after a strobe edge that captures a sum of launched operands. It stays low after the first strobe edge following reset.
- R6: With `CARRY_EN`=1, `carry_o` is the carry out of bit DATA_W-1 of the same sum and is updated together with `sum_o`. With `CARRY_EN`=0, `carry_o` is always 0.
- R7: A reset asserted mid-operation clears the pending sum, restarts the cadence of R2, and suppresses valid on the first following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| sum_o | output | DATA_W | Registered sum, modulo 2^DATA_W |
| carry_o | output | 1 | Registered carry out (0 when CARRY_EN=0) |
| strobe_o | output | 1 | Shared load strobe; the next rising edge loads all gated registers |
| valid_o | output | 1 | One-cycle pulse after each new sum |

## Verification
A vector table drives operand pairs that separate a correct full-width adder from common faults. Zero plus zero and a small pair test the plain path. All-ones plus one and two copies of the top bit wrap to zero and raise the carry. A 32-bit run of ones plus one exposes a break in the carry chain at mid-width. All-ones plus all-ones and an alternating pair test wide propagation. Between strobes the bench applies random operands and checks that the result and valid stay put, which catches a register that ignores its enable. Directed resets at start-up and mid-stream confirm the cadence of the first strobe and that valid stays low for the unprimed first capture.

// File: rtl/mca_pkg.sv
package mca_pkg;

    // Sequencer state: does the result register hold a sum of launched operands?
    typedef enum logic [0:0] {
        SEQ_EMPTY  = 1'b0,
        SEQ_PRIMED = 1'b1
    } seq_state_e;

    // Number of clocks the adder may take to settle; also the ring length.
    localparam int unsigned WINDOW_CYCLES = 3;

endpackage

// File: rtl/mca_phase_ring.sv
module mca_phase_ring #(
    parameter int unsigned STAGES = mca_pkg::WINDOW_CYCLES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [STAGES-1:0] ring_o,
    output logic              fire_o
);
    localparam logic [STAGES-1:0] RING_INIT = {{(STAGES-1){1'b0}}, 1'b1};

    logic [STAGES-1:0] ring_q;
    logic [STAGES-1:0] ring_d;

    // Rotate toward the MSB; the top bit wraps back into bit 0.
    generate
        if (STAGES == 1) begin : g_single
            assign ring_d = ring_q;
        end else begin : g_rotate
            assign ring_d = {ring_q[STAGES-2:0], ring_q[STAGES-1]};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ring_q <= RING_INIT;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign ring_o = ring_q;
    assign fire_o = ring_q[STAGES-1];

endmodule

// File: rtl/mca_en_reg.sv
module mca_en_reg #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_r <= '0;
        end else if (load_i) begin
            q_r <= d_i;
        end
    end

    assign q_o = q_r;

endmodule

// File: rtl/mca_adder.sv
module mca_adder #(
    parameter int unsigned WIDTH    = 64,
    parameter bit          CARRY_EN = 1'b0
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    generate
        if (CARRY_EN) begin : g_carry
            logic [WIDTH:0] wide;
            assign wide    = {1'b0, a_i} + {1'b0, b_i};
            assign sum_o   = wide[WIDTH-1:0];
            assign carry_o = wide[WIDTH];
        end else begin : g_nocarry
            assign sum_o   = a_i + b_i;
            assign carry_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mca_seq.sv
module mca_seq (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fire_i,
    output logic valid_o
);
    import mca_pkg::*;

    seq_state_e state_q;
    seq_state_e state_d;
    logic       valid_d;
    logic       valid_q;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_EMPTY;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= valid_d;
        end
    end

    // Next state and output decode
    always_comb begin
        state_d = state_q;
        valid_d = 1'b0;
        unique case (state_q)
            SEQ_EMPTY: begin
                if (fire_i) begin
                    state_d = SEQ_PRIMED;
                end
            end
            SEQ_PRIMED: begin
                valid_d = fire_i;
            end
            default: begin
                state_d = SEQ_EMPTY;
            end
        endcase
    end

    assign valid_o = valid_q;

endmodule

// File: rtl/mca_wide_adder.sv
module mca_wide_adder #(
    parameter int unsigned DATA_W   = 64,
    parameter bit          CARRY_EN = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              strobe_o,
    output logic              valid_o
);
    localparam int unsigned STAGES = mca_pkg::WINDOW_CYCLES;

    logic [STAGES-1:0] ring_state;
    logic              fire;
    logic [DATA_W-1:0] opa_q;
    logic [DATA_W-1:0] opb_q;
    logic [DATA_W-1:0] sum_comb;
    logic              carry_comb;

    mca_phase_ring #(.STAGES(STAGES)) u_ring (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ring_o (ring_state),
        .fire_o (fire)
    );

    mca_en_reg #(.WIDTH(DATA_W)) u_opa_reg (
        .clk_i (clk_i), .rst_i (rst_i), .load_i (fire), .d_i (opa_i), .q_o (opa_q)
    );

    mca_en_reg #(.WIDTH(DATA_W)) u_opb_reg (
        .clk_i (clk_i), .rst_i (rst_i), .load_i (fire), .d_i (opb_i), .q_o (opb_q)
    );

    mca_adder #(.WIDTH(DATA_W), .CARRY_EN(CARRY_EN)) u_add (
        .a_i     (opa_q),
        .b_i     (opb_q),
        .sum_o   (sum_comb),
        .carry_o (carry_comb)
    );

    mca_en_reg #(.WIDTH(DATA_W + 1)) u_res_reg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (fire),
        .d_i    ({carry_comb, sum_comb}),
        .q_o    ({carry_o, sum_o})
    );

    mca_seq u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .fire_i  (fire),
        .valid_o (valid_o)
    );

    assign strobe_o = fire;

endmodule

// File: rtl/mca_wide_adder_chk.sv
module mca_wide_adder_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned STAGES = 3
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [DATA_W-1:0] sum_o,
    input logic              strobe_o,
    input logic              valid_o,
    input logic [STAGES-1:0] ring_state
);
    localparam int unsigned GAP_W = $clog2(STAGES + 1);

    logic              out_of_reset;
    logic [GAP_W-1:0]  gap_q;
    logic [DATA_W-1:0] launch_sum_q;
    logic [DATA_W-1:0] expect_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_of_reset <= 1'b0;
            gap_q        <= '0;
            launch_sum_q <= '0;
            expect_q     <= '0;
        end else begin
            out_of_reset <= 1'b1;
            if (strobe_o) begin
                gap_q        <= '0;
                expect_q     <= launch_sum_q;
                launch_sum_q <= opa_i + opb_i;
            end else if (gap_q < GAP_W'(STAGES)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (sum_o == '0 && !valid_o && !strobe_o)); // R1

    AST_RING_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(ring_state) == 1); // R2

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o); // R2

    AST_STROBE_CADENCE: assert property (@(posedge clk_i) disable iff (rst_i)
        gap_q < GAP_W'(STAGES)); // R2

    AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_of_reset && !$past(strobe_o)) |-> $stable(sum_o)); // R3

    AST_SUM_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (sum_o == expect_q)); // R4

    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (out_of_reset && $past(strobe_o))); // R5

endmodule

bind mca_wide_adder mca_wide_adder_chk #(.DATA_W(DATA_W), .STAGES(STAGES)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .sum_o      (sum_o),
    .strobe_o   (strobe_o),
    .valid_o    (valid_o),
    .ring_state (ring_state)
);

// File: tb/mca_wide_adder_tb.sv
module mca_wide_adder_tb;
    localparam int unsigned W  = 64;
    localparam int unsigned NV = 8;

    // {operand A, operand B}
    localparam logic [2*W-1:0] VEC [NV] = '{
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
        {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
        {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001},
        {64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
        {64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_90AB_CDEF}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] sum, sum_c;
    logic         carry, carry_c, strobe, strobe_c, valid, valid_c;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk; // 50 MHz

    mca_wide_adder #(.DATA_W(W), .CARRY_EN(1'b0)) u_dut (
        .clk_i (clk), .rst_i (rst), .opa_i (opa), .opb_i (opb),
        .sum_o (sum), .carry_o (carry), .strobe_o (strobe), .valid_o (valid)
    );

    mca_wide_adder #(.DATA_W(W), .CARRY_EN(1'b1)) u_dut_c (
        .clk_i (clk), .rst_i (rst), .opa_i (opa), .opb_i (opb),
        .sum_o (sum_c), .carry_o (carry_c), .strobe_o (strobe_c), .valid_o (valid_c)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Hold reset over two edges, release at a falling edge, then expect the
    // first strobe at the second falling edge (R2) and cleared outputs (R1).
    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(sum == '0 && sum_c == '0, "R1", "sum after reset", {1'b0, sum}, '0);
        check(!valid && !strobe && !carry_c, "R1", "flags after reset",
              {valid, strobe, carry_c}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!strobe, "R2", "no strobe one cycle after release", {64'd0, strobe}, '0);
        @(negedge clk);
        check(strobe && strobe_c, "R2", "first strobe", {64'd0, strobe}, 1);
    endtask

    // Called at a falling edge where strobe is high.
    // Drives a pair, lets it be captured, checks the previous pair's result.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit have_prev, input logic [W:0] prev_full, input string req);
        logic [W-1:0] held;
        opa = a;
        opb = b;
        @(negedge clk);
        if (have_prev) begin
            check(sum == prev_full[W-1:0], req, "sum", {1'b0, sum}, {1'b0, prev_full[W-1:0]});
            check(sum_c == prev_full[W-1:0] && carry_c == prev_full[W], "R6", "carry instance",
                  {carry_c, sum_c}, prev_full);
            check(!carry, "R6", "carry disabled stays 0", {64'd0, carry}, '0);
            check(valid && valid_c, "R5", "valid after capture", {64'd0, valid}, 1);
        end else begin
            check(!valid && !valid_c, "R5", "no valid on unprimed capture", {64'd0, valid}, '0);
        end
        // Disturb operands between strobes; outputs must hold (R3).
        held = sum;
        opa  = {$urandom, $urandom};
        opb  = {$urandom, $urandom};
        @(negedge clk);
        check(sum == held, "R3", "sum held between strobes", {1'b0, sum}, {1'b0, held});
        check(!valid && !strobe, "R5", "valid one cycle only", {valid, strobe}, '0);
        opa = {$urandom, $urandom};
        opb = {$urandom, $urandom};
        @(negedge clk);
        check(strobe, "R2", "strobe every third cycle", {64'd0, strobe}, 1);
        check(sum == held, "R3", "sum held second cycle", {1'b0, sum}, {1'b0, held});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [W:0] prev_full;
        bit         have_prev;

        do_reset();

        // Table walk: R4 sums, R5 valid, R6 carry, R3 hold
        have_prev = 1'b0;
        prev_full = '0;
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] a, b;
            a = VEC[i][2*W-1:W];
            b = VEC[i][W-1:0];
            step(a, b, have_prev, prev_full, "R4");
            prev_full = {1'b0, a} + {1'b0, b};
            have_prev = 1'b1;
        end
        step(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAB, 1'b1, prev_full, "R4");
        prev_full = {1'b0, 64'h5555_5555_5555_5555} + {1'b0, 64'hAAAA_AAAA_AAAA_AAAB};
        step(64'd7, 64'd9, 1'b1, prev_full, "R4");

        // R7: reset mid-operation drops the pending sum and restarts cadence
        opa = 64'd100;
        opb = 64'd200;
        @(negedge clk);
        do_reset();
        check(sum == '0, "R7", "pending sum dropped", {1'b0, sum}, '0);
        step(64'd3, 64'd4, 1'b0, '0, "R7");
        step(64'd1, 64'd1, 1'b1, 65'd7, "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule